// File: doc/BRIEF.md
# Dispatch Steering with Queue Bypass

This block sits between register renaming and the instruction queue of an out-of-order core. Each cycle it takes a bundle of up to `WIDTH` renamed instructions and decides, slot by slot, where each one goes. There are two destinations. An ordinary instruction is sent to the instruction queue with an insert strobe. Memory references, non-speculative instructions and no-ops skip the queue. For each of these the block raises a bypass strobe, which marks the instruction as issued, executed and ready to commit, and the queue tail is moved past it.

Slots are visited in order, starting at slot 0, and the walk ends at the first empty slot. A slot that needs a queue entry while the queue reports full stops the walk. The block then raises a block request, which also stalls the upstream stages, and reports the index of the slot where it stopped so the controller knows which slots must be replayed. No steering takes place in a cycle in which the stage is squashing. The number of slots examined per cycle equals the issue width.

All results are registered, so they appear one clock after the inputs that produced them. The storage of the queue and the choice of instructions to issue from it are handled elsewhere.

Top module: `dispatch_steer`

## Requirements
- R1: Slots are scanned from slot 0 upward (bit i of every per-slot vector belongs to slot i). The scan stops at the first slot whose valid bit is low, and that slot and every slot above it receive no strobe, whatever their class flags are.
- R2: A valid slot with all class flags low, reached while the queue is not full, gets its bit set in `insert_o`. The result is due one clock edge after the inputs.
- R3: A reached valid slot with its memory-reference flag set gets its bit set in `bypass_o`, which stands for issued, executed and can-commit. It never gets an insert strobe, even when the queue is full.
- R4: A reached valid slot flagged non-speculative or no-op is treated exactly like a memory reference: it gets a bypass strobe and no insert strobe.
- R5: When a reached valid slot needs insertion and `iq_full_i` is high, `block_o` goes high. That slot and all later slots receive no strobe, and slots below it keep their strobes.
- R6: While `block_o` is high, `replay_idx_o` holds the index of the slot where the scan stopped. Otherwise it is 0.
- R7: `tail_adv_o` equals the number of slots that received a bypass strobe in the same cycle.
- R8: When `squash_i` is high, the next cycle shows no insert strobe, no bypass strobe, no block and a zero tail advance, even if the queue is full.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| squash_i | input | 1 | Stage is squashing; suppress all steering |
| iq_full_i | input | 1 | Instruction queue has no free entry |
| slot_valid_i | input | WIDTH | Per-slot valid bit |
| slot_mem_i | input | WIDTH | Per-slot memory-reference flag |
| slot_nonspec_i | input | WIDTH | Per-slot non-speculative flag |
| slot_nop_i | input | WIDTH | Per-slot no-op flag |
| insert_o | output | WIDTH | Per-slot queue insert strobe |
| bypass_o | output | WIDTH | Per-slot bypass strobe (issued, executed, can-commit) |
| tail_adv_o | output | $clog2(WIDTH+1) | Number of tail advances for bypassed slots |
| block_o | output | 1 | Block request; stalls upstream |
| replay_idx_o | output | max(1,$clog2(WIDTH)) | First slot that was not processed when blocked |

## Verification
Every output of this block comes from a single register stage. The insert and bypass strobes, the tail count, the block request and the replay index are therefore all due at the first rising edge after the bundle is presented. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, so exactly one rising edge lies between stimulus and check. The reset checks read the outputs while reset is still held, after an edge at which the inputs requested activity. The properties tie each output to the inputs from the previous cycle through `$past`.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // Result of classifying one dispatch slot.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,   // no instruction, ends the scan
        SLOT_QUEUE = 2'd1,   // needs an instruction-queue entry
        SLOT_SKIP  = 2'd2    // completes without the queue
    } slot_kind_e;

endpackage

// File: rtl/steer_classify.sv
module steer_classify
    import steer_pkg::*;
(
    input  logic       valid_i,
    input  logic       mem_i,
    input  logic       nonspec_i,
    input  logic       nop_i,
    output slot_kind_e kind_o
);

    // Classification comes before any fullness test, so skip-class
    // slots never depend on queue space (R3, R4).
    always_comb begin
        if (!valid_i) begin
            kind_o = SLOT_EMPTY;
        end else if (mem_i || nonspec_i || nop_i) begin
            kind_o = SLOT_SKIP;
        end else begin
            kind_o = SLOT_QUEUE;
        end
    end

endmodule

// File: rtl/steer_scan.sv
module steer_scan
    import steer_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int IDXW  = 2,
    parameter int CNTW  = 3
) (
    input  slot_kind_e [WIDTH-1:0] kind_i,
    input  logic                   full_i,
    input  logic                   squash_i,
    output logic [WIDTH-1:0]       insert_o,
    output logic [WIDTH-1:0]       bypass_o,
    output logic                   block_o,
    output logic [IDXW-1:0]        idx_o,
    output logic [CNTW-1:0]        count_o
);

    // Ordered walk: a running enable drops at an empty slot (R1) or at a
    // queue slot that meets a full queue (R5).
    always_comb begin
        logic go;
        go       = !squash_i;        // R8: no dispatch while squashing
        insert_o = '0;
        bypass_o = '0;
        block_o  = 1'b0;
        idx_o    = '0;
        count_o  = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (go) begin
                unique case (kind_i[i])
                    SLOT_EMPTY: go = 1'b0;
                    SLOT_SKIP: begin
                        bypass_o[i] = 1'b1;
                        count_o     = count_o + CNTW'(1);
                    end
                    SLOT_QUEUE: begin
                        if (full_i) begin
                            block_o = 1'b1;
                            idx_o   = IDXW'(i);   // R6
                            go      = 1'b0;
                        end else begin
                            insert_o[i] = 1'b1;
                        end
                    end
                    default: go = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dispatch_steer.sv
module dispatch_steer
    import steer_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int CNTW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             squash_i,
    input  logic             iq_full_i,
    input  logic [WIDTH-1:0] slot_valid_i,
    input  logic [WIDTH-1:0] slot_mem_i,
    input  logic [WIDTH-1:0] slot_nonspec_i,
    input  logic [WIDTH-1:0] slot_nop_i,
    output logic [WIDTH-1:0] insert_o,
    output logic [WIDTH-1:0] bypass_o,
    output logic [CNTW-1:0]  tail_adv_o,
    output logic             block_o,
    output logic [IDXW-1:0]  replay_idx_o
);

    typedef struct packed {
        logic [WIDTH-1:0] ins;
        logic [WIDTH-1:0] byp;
        logic [CNTW-1:0]  tail;
        logic             blk;
        logic [IDXW-1:0]  idx;
    } steer_state_t;

    slot_kind_e [WIDTH-1:0] kind;
    logic [WIDTH-1:0]       scan_ins;
    logic [WIDTH-1:0]       scan_byp;
    logic                   scan_blk;
    logic [IDXW-1:0]        scan_idx;
    logic [CNTW-1:0]        scan_cnt;
    steer_state_t           state_d;
    steer_state_t           state_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_cls
        steer_classify u_cls (
            .valid_i   (slot_valid_i[g]),
            .mem_i     (slot_mem_i[g]),
            .nonspec_i (slot_nonspec_i[g]),
            .nop_i     (slot_nop_i[g]),
            .kind_o    (kind[g])
        );
    end

    steer_scan #(
        .WIDTH (WIDTH),
        .IDXW  (IDXW),
        .CNTW  (CNTW)
    ) u_scan (
        .kind_i   (kind),
        .full_i   (iq_full_i),
        .squash_i (squash_i),
        .insert_o (scan_ins),
        .bypass_o (scan_byp),
        .block_o  (scan_blk),
        .idx_o    (scan_idx),
        .count_o  (scan_cnt)
    );

    always_comb begin
        state_d      = state_q;
        state_d.ins  = scan_ins;
        state_d.byp  = scan_byp;
        state_d.tail = scan_cnt;
        state_d.blk  = scan_blk;
        state_d.idx  = scan_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;                       // R9
        end else begin
            state_q <= state_d;
        end
    end

    assign insert_o     = state_q.ins;
    assign bypass_o     = state_q.byp;
    assign tail_adv_o   = state_q.tail;
    assign block_o      = state_q.blk;
    assign replay_idx_o = state_q.idx;

    // Strobed slots must form a contiguous run starting at slot 0.
    logic [WIDTH-1:0] touched;
    assign touched = state_q.ins | state_q.byp;

    p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((touched + WIDTH'(1)) & touched) == '0);

    p_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insert_o & bypass_o) == '0);

    p_full_no_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(iq_full_i) |-> insert_o == '0);

    p_block_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        block_o |-> $past(iq_full_i));

    p_idx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !block_o |-> replay_idx_o == '0);

    p_tail_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tail_adv_o) == $countones(bypass_o));

    p_squash_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(squash_i) |-> (insert_o == '0 && bypass_o == '0 && !block_o));

endmodule

// File: tb/sim_dispatch_steer.sv
`timescale 1ns/1ps
module sim_dispatch_steer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       squash_i;
    logic       iq_full_i;
    logic [3:0] slot_valid_i, slot_mem_i, slot_nonspec_i, slot_nop_i;
    logic [3:0] insert_o, bypass_o;
    logic [2:0] tail_adv_o;
    logic       block_o;
    logic [1:0] replay_idx_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dispatch_steer #(.WIDTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .squash_i(squash_i), .iq_full_i(iq_full_i),
        .slot_valid_i(slot_valid_i), .slot_mem_i(slot_mem_i),
        .slot_nonspec_i(slot_nonspec_i), .slot_nop_i(slot_nop_i),
        .insert_o(insert_o), .bypass_o(bypass_o), .tail_adv_o(tail_adv_o),
        .block_o(block_o), .replay_idx_o(replay_idx_o)
    );

    // Bit i of each nibble is slot i.
    typedef struct packed {
        logic [3:0] req;
        logic [3:0] v, m, ns, nop;
        logic       full, sq;
        logic [3:0] ei, eb;
        logic [2:0] et;
        logic       ebk;
        logic [1:0] ex;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{4'd2, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b1111, 4'b0000, 3'd0, 1'b0, 2'd0}, // R2 full bundle
        '{4'd2, 4'b0111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0111, 4'b0000, 3'd0, 1'b0, 2'd0}, // R2 partial
        '{4'd1, 4'b1101, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0001, 4'b0000, 3'd0, 1'b0, 2'd0}, // R1 hole at slot1
        '{4'd3, 4'b1111, 4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b1101, 4'b0010, 3'd1, 1'b0, 2'd0}, // R3 memory slot
        '{4'd4, 4'b1111, 4'b0000, 4'b0100, 4'b1000, 1'b0, 1'b0, 4'b0011, 4'b1100, 3'd2, 1'b0, 2'd0}, // R4 nonspec+nop
        '{4'd5, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0000, 3'd0, 1'b1, 2'd0}, // R5 full at slot0
        '{4'd6, 4'b1111, 4'b0001, 4'b0010, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0011, 3'd2, 1'b1, 2'd2}, // R6 stop at slot2
        '{4'd7, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b1111, 3'd4, 1'b0, 2'd0}, // R7 all bypass
        '{4'd3, 4'b0011, 4'b0011, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0011, 3'd2, 1'b0, 2'd0}, // R3 full, no block
        '{4'd8, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 4'b0000, 4'b0000, 3'd0, 1'b0, 2'd0}, // R8 squash
        '{4'd6, 4'b1111, 4'b0000, 4'b0000, 4'b0111, 1'b1, 1'b0, 4'b0000, 4'b0111, 3'd3, 1'b1, 2'd3}, // R6 stop at slot3
        '{4'd1, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000, 4'b0000, 3'd0, 1'b0, 2'd0}, // R1 empty bundle
        '{4'd5, 4'b1111, 4'b0100, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0000, 3'd0, 1'b1, 2'd0}, // R5 later slots dropped
        '{4'd1, 4'b0001, 4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0001, 4'b0000, 3'd0, 1'b0, 2'd0}  // R1 flags on invalid slot
    };

    task automatic drive(input vec_t t);
        slot_valid_i   = t.v;
        slot_mem_i     = t.m;
        slot_nonspec_i = t.ns;
        slot_nop_i     = t.nop;
        iq_full_i      = t.full;
        squash_i       = t.sq;
    endtask

    task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got ins/byp/tail/blk/idx=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] outs();
        return {insert_o, bypass_o, tail_adv_o, block_o, replay_idx_o};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: reset holds outputs at zero although inputs request work
        rst_n = 1'b0;
        drive(TBL[0]);
        repeat (3) @(negedge clk);
        check("R9 reset", outs(), 15'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(TBL[k]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[k].req, k), outs(),
                  {TBL[k].ei, TBL[k].eb, TBL[k].et, TBL[k].ebk, TBL[k].ex});
        end

        // R8: squash drops a block that would otherwise occur
        drive(TBL[6]);
        @(negedge clk);
        check("R6 block before squash", outs(), {4'b0000, 4'b0011, 3'd2, 1'b1, 2'd2});
        squash_i = 1'b1;
        @(negedge clk);
        check("R8 squash clears block", outs(), 15'd0);
        squash_i = 1'b0;
        @(negedge clk);
        check("R5 block returns after squash", outs(), {4'b0000, 4'b0011, 3'd2, 1'b1, 2'd2});

        // R2: queue frees up, same bundle now inserts
        iq_full_i = 1'b0;
        slot_mem_i = 4'b0000;
        slot_nonspec_i = 4'b0000;
        @(negedge clk);
        check("R2 queue freed", outs(), {4'b1111, 4'b0000, 3'd0, 1'b0, 2'd0});

        // R9: mid-run reset clears registered results
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset", outs(), 15'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule